// File: doc/BRIEF.md
# Debugger Target Reset Sequencer

This block sits on the debug probe side of a target connection and drives two independent active-low reset lines toward the target: the system reset and the test-logic reset. Both are modelled as open-drain pull-downs. Each output is an enable that, when high, pulls its line low. When it is low, the line is left to the target's pull-up. The block never drives either line high.

A connect request runs an ordered sequence. The system reset is pulled low and held there. The test-logic reset is pulsed while the system reset is held. An external agent is then asked, through a request/acknowledge pair, to configure the debug module while the core is still held in reset. Only after the acknowledge is the system reset released. A programmable settle time must pass before the target is reported ready. If the acknowledge never comes, a timeout ends the sequence with an error flag.

A second request issues a system reset pulse of programmable width. The block also senses the shared system reset line, which the target may pull low by itself. Such events can be captured in a sticky flag so that short pulses are not missed, and they can optionally raise a halt request. In hot-attach mode the connect request leaves both lines released and reports that attaching is safe.

Top module: `dbg_rst_seq`

## Requirements
- R1: After reset, srst_pull, trst_pull, cfg_req, ready, attach_safe, busy, cfg_timeout_err, tgt_rst_seen and halt_req are all 0.
- R2: A connect_start accepted with hot_attach=0 sets both srst_pull and trst_pull to 1 in the cycle after the accepting edge. trst_pull stays 1 for max(trst_cycles,1) cycles, and srst_pull stays 1 throughout.
- R3: When trst_pull falls, cfg_req rises in the same cycle while srst_pull stays 1. Both hold until an acknowledge arrives or the timeout expires.
- R4: The edge that samples cfg_ack=1 during the request clears srst_pull and cfg_req. ready rises max(settle_cycles,1) cycles after that edge, and trst_pull stays 0 meanwhile.
- R5: If cfg_ack stays 0, cfg_req stays 1 for ack_timeout+1 cycles. Both pulls are then released, ready stays 0 and cfg_timeout_err becomes 1. cfg_timeout_err clears on the next accepted connect_start.
- R6: A user_rst_start accepted while idle, ready or attached sets srst_pull for max(pulse_cycles,1) cycles with trst_pull at 0, then releases it. ready is 0 afterwards.
- R7: With latch_en=1, a target-driven low on srst_line lasting at least one clock cycle, at a time when srst_pull has been 0 for 3 or more cycles, sets tgt_rst_seen on the third rising edge after the line falls. The flag then holds until an edge that samples status_read=1 clears it.
- R8: With latch_en=0, tgt_rst_seen follows the synchronised line: 1 while the target holds it low, and 0 again three edges after the line returns high, with no read needed.
- R9: With halt_on_rst=1, halt_req is a one-cycle pulse in the same cycle as the detection of a target reset. With halt_on_rst=0, halt_req stays 0.
- R10: A connect_start accepted with hot_attach=1 leaves srst_pull and trst_pull at 0, sets attach_safe to 1 and never raises cfg_req.
- R11: connect_start and user_rst_start are ignored while busy=1, which covers the test-logic pulse, the configuration wait, the settle wait and the user pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hot_attach | input | 1 | Connect without touching either reset line |
| latch_en | input | 1 | Make the target-reset flag sticky |
| halt_on_rst | input | 1 | Raise halt_req when a target reset is seen |
| trst_cycles | input | CW | Test-logic reset pulse width in cycles (0 treated as 1) |
| pulse_cycles | input | CW | User system reset pulse width in cycles (0 treated as 1) |
| settle_cycles | input | CW | Wait after system reset release before ready (0 treated as 1) |
| ack_timeout | input | CW | Extra cycles to wait for cfg_ack |
| connect_start | input | 1 | One-cycle connect request |
| user_rst_start | input | 1 | One-cycle user reset pulse request |
| cfg_ack | input | 1 | Debug module configuration done |
| status_read | input | 1 | Clears the sticky target-reset flag |
| srst_line | input | 1 | Sensed level of the shared system reset line |
| srst_pull | output | 1 | 1 pulls the system reset line low, 0 leaves it floating |
| trst_pull | output | 1 | 1 pulls the test-logic reset line low, 0 leaves it floating |
| cfg_req | output | 1 | Request to configure the debug module under reset |
| ready | output | 1 | Connect done, target released and settled |
| attach_safe | output | 1 | Hot attach active, cable may be connected |
| busy | output | 1 | A sequence or pulse is in progress |
| cfg_timeout_err | output | 1 | Last connect ended without acknowledge |
| tgt_rst_seen | output | 1 | Target-driven reset detected |
| halt_req | output | 1 | One-cycle request to halt the core after a target reset |

## Verification
Pull outputs change one cycle after the edge that accepts a request. After that, every pull and request window is measured by counting falling-edge samples: max(trst_cycles,1) for the test-logic pulse, ack_timeout+1 for an unanswered request, max(settle_cycles,1) from release to ready, and max(pulse_cycles,1) for a user pulse. The sensed line passes through two flip-flops before detection. A target low driven after an edge therefore shows in tgt_rst_seen and halt_req only after the third following edge. The bench samples one falling edge before that point to see 0, and at that point to see 1. A clear by read is checked at the falling edge after the read edge.

// File: rtl/dbg_rst_seq.sv
module dbg_rst_seq #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hot_attach,
  input  logic          latch_en,
  input  logic          halt_on_rst,
  input  logic [CW-1:0] trst_cycles,
  input  logic [CW-1:0] pulse_cycles,
  input  logic [CW-1:0] settle_cycles,
  input  logic [CW-1:0] ack_timeout,
  input  logic          connect_start,
  input  logic          user_rst_start,
  input  logic          cfg_ack,
  input  logic          status_read,
  input  logic          srst_line,
  output logic          srst_pull,
  output logic          trst_pull,
  output logic          cfg_req,
  output logic          ready,
  output logic          attach_safe,
  output logic          busy,
  output logic          cfg_timeout_err,
  output logic          tgt_rst_seen,
  output logic          halt_req
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_TRST, ST_CFG, ST_SETTLE, ST_READY, ST_PULSE, ST_ATTACH
  } st_t;

  localparam logic [CW-1:0] ONE = CW'(1);

  st_t           st;
  logic [CW-1:0] cnt;
  logic          sy1, sy2, own_d1, own_d2, det, det_q;
  logic          accept;

  assign srst_pull   = (st == ST_TRST) || (st == ST_CFG) || (st == ST_PULSE);
  assign trst_pull   = (st == ST_TRST);
  assign cfg_req     = (st == ST_CFG);
  assign ready       = (st == ST_READY);
  assign attach_safe = (st == ST_ATTACH);
  assign busy        = !((st == ST_IDLE) || (st == ST_READY) || (st == ST_ATTACH));
  assign accept      = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st              <= ST_IDLE;
      cnt             <= '0;
      cfg_timeout_err <= 1'b0;
    end else begin
      case (st)
        ST_TRST: begin
          if (cnt <= ONE) begin
            st  <= ST_CFG;
            cnt <= '0;
          end else cnt <= cnt - ONE;
        end
        ST_CFG: begin
          if (cfg_ack) begin
            st  <= ST_SETTLE;
            cnt <= settle_cycles;
          end else if (cnt == ack_timeout) begin
            st              <= ST_IDLE;
            cfg_timeout_err <= 1'b1;
          end else cnt <= cnt + ONE;
        end
        ST_SETTLE: begin
          if (cnt <= ONE) st <= ST_READY;
          else cnt <= cnt - ONE;
        end
        ST_PULSE: begin
          if (cnt <= ONE) st <= ST_IDLE;
          else cnt <= cnt - ONE;
        end
        default: begin
          if (accept && connect_start) begin
            cfg_timeout_err <= 1'b0;
            if (hot_attach) st <= ST_ATTACH;
            else begin
              st  <= ST_TRST;
              cnt <= trst_cycles;
            end
          end else if (accept && user_rst_start) begin
            st  <= ST_PULSE;
            cnt <= pulse_cycles;
          end
        end
      endcase
    end
  end

  // Sensed line: two-stage synchroniser, own drive masked while it propagates
  assign det = !sy2 && !srst_pull && !own_d1 && !own_d2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1          <= 1'b1;
      sy2          <= 1'b1;
      own_d1       <= 1'b0;
      own_d2       <= 1'b0;
      det_q        <= 1'b0;
      tgt_rst_seen <= 1'b0;
      halt_req     <= 1'b0;
    end else begin
      sy1      <= srst_line;
      sy2      <= sy1;
      own_d1   <= srst_pull;
      own_d2   <= own_d1;
      det_q    <= det;
      halt_req <= halt_on_rst && det && !det_q;
      if (latch_en) tgt_rst_seen <= det || (tgt_rst_seen && !status_read);
      else          tgt_rst_seen <= det;
    end
  end
endmodule

// File: rtl/dbg_rst_seq_chk.sv
module dbg_rst_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic srst_pull,
  input logic trst_pull,
  input logic cfg_req,
  input logic ready,
  input logic attach_safe,
  input logic halt_req,
  input logic tgt_rst_seen,
  input logic status_read,
  input logic latch_en
);
  // R2
  trst_under_srst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trst_pull |-> srst_pull);

  // R3
  trst_release_keeps_srst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trst_pull) |-> (srst_pull && cfg_req));

  // R3
  cfg_under_srst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> (srst_pull && !trst_pull));

  // R4
  ready_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!srst_pull && !trst_pull && !cfg_req));

  // R4
  ready_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> !$past(srst_pull));

  // R10
  attach_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    attach_safe |-> (!srst_pull && !trst_pull && !cfg_req));

  // R9
  halt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |=> !halt_req);

  // R7
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_en && tgt_rst_seen && !status_read) |=> (tgt_rst_seen || !latch_en));
endmodule

bind dbg_rst_seq dbg_rst_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .srst_pull(srst_pull), .trst_pull(trst_pull),
  .cfg_req(cfg_req), .ready(ready), .attach_safe(attach_safe),
  .halt_req(halt_req), .tgt_rst_seen(tgt_rst_seen),
  .status_read(status_read), .latch_en(latch_en)
);

// File: tb/sim_dbg_rst_seq.sv
module sim_dbg_rst_seq;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hot_attach = 0, latch_en = 1, halt_on_rst = 0;
  logic [CW-1:0] trst_cycles = 3, pulse_cycles = 4, settle_cycles = 5, ack_timeout = 6;
  logic connect_start = 0, user_rst_start = 0, cfg_ack = 0, status_read = 0;
  logic tgt_pull = 0;
  logic srst_line;
  logic srst_pull, trst_pull, cfg_req, ready, attach_safe, busy;
  logic cfg_timeout_err, tgt_rst_seen, halt_req;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign srst_line = !(srst_pull || tgt_pull);

  dbg_rst_seq #(.CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .hot_attach(hot_attach), .latch_en(latch_en),
    .halt_on_rst(halt_on_rst), .trst_cycles(trst_cycles), .pulse_cycles(pulse_cycles),
    .settle_cycles(settle_cycles), .ack_timeout(ack_timeout),
    .connect_start(connect_start), .user_rst_start(user_rst_start), .cfg_ack(cfg_ack),
    .status_read(status_read), .srst_line(srst_line), .srst_pull(srst_pull),
    .trst_pull(trst_pull), .cfg_req(cfg_req), .ready(ready), .attach_safe(attach_safe),
    .busy(busy), .cfg_timeout_err(cfg_timeout_err), .tgt_rst_seen(tgt_rst_seen),
    .halt_req(halt_req)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic go_idle();
    @(negedge clk) user_rst_start = 1;
    @(negedge clk) user_rst_start = 0;
    while (busy) @(negedge clk);
    cyc(4);
  endtask

  task automatic t_reset();
    chk({srst_pull, trst_pull, cfg_req, ready, attach_safe, busy, cfg_timeout_err,
         tgt_rst_seen, halt_req} == 9'd0, "R1 outputs after reset",
        int'({srst_pull, trst_pull, cfg_req, ready, attach_safe, busy}), 0);
  endtask

  task automatic t_connect(input int n, input int s);
    int c;
    int trst_bad;
    trst_cycles = CW'(n);
    settle_cycles = CW'(s);
    ack_timeout = 40;
    @(negedge clk) connect_start = 1;
    @(negedge clk) connect_start = 0;
    chk(srst_pull && trst_pull, "R2 both pulls after start", int'({srst_pull, trst_pull}), 3);
    c = 0;
    while (trst_pull && c < 100) begin
      if (!srst_pull) chk(0, "R2 srst held during trst", 0, 1);
      c++;
      @(negedge clk);
    end
    chk(c == ((n < 1) ? 1 : n), "R2 trst width", c, (n < 1) ? 1 : n);
    chk(cfg_req && srst_pull, "R3 cfg_req under srst", int'({cfg_req, srst_pull}), 3);
    cyc(3);
    chk(cfg_req && srst_pull, "R3 request held without ack", int'({cfg_req, srst_pull}), 3);
    connect_start = 1;
    user_rst_start = 1;
    @(negedge clk);
    connect_start = 0;
    user_rst_start = 0;
    chk(cfg_req && srst_pull && !trst_pull, "R11 requests ignored while busy",
        int'({cfg_req, srst_pull, trst_pull}), 6);
    cfg_ack = 1;
    @(negedge clk) cfg_ack = 0;
    chk(!srst_pull && !cfg_req && !ready, "R4 srst released on ack",
        int'({srst_pull, cfg_req, ready}), 0);
    c = 0;
    trst_bad = 0;
    while (!ready && c < 100) begin
      if (trst_pull) trst_bad++;
      c++;
      @(negedge clk);
    end
    chk(c == ((s < 1) ? 1 : s), "R4 settle to ready", c, (s < 1) ? 1 : s);
    chk(trst_bad == 0 && !srst_pull, "R4 lines released at ready", trst_bad, 0);
  endtask

  task automatic t_timeout(input int t);
    int c;
    trst_cycles = 1;
    ack_timeout = CW'(t);
    @(negedge clk) connect_start = 1;
    @(negedge clk) connect_start = 0;
    while (trst_pull) @(negedge clk);
    c = 0;
    while (cfg_req && c < 100) begin
      c++;
      @(negedge clk);
    end
    chk(c == t + 1, "R5 request window", c, t + 1);
    chk(cfg_timeout_err == 1, "R5 error flag", int'(cfg_timeout_err), 1);
    chk(!srst_pull && !trst_pull && !ready, "R5 released without ready",
        int'({srst_pull, trst_pull, ready}), 0);
    ack_timeout = 40;
    @(negedge clk) connect_start = 1;
    @(negedge clk) connect_start = 0;
    chk(cfg_timeout_err == 0, "R5 error cleared on new connect", int'(cfg_timeout_err), 0);
    while (!cfg_req) @(negedge clk);
    cfg_ack = 1;
    @(negedge clk) cfg_ack = 0;
    while (!ready) @(negedge clk);
  endtask

  task automatic t_user_pulse(input int p);
    int c;
    int tb;
    pulse_cycles = CW'(p);
    @(negedge clk) user_rst_start = 1;
    @(negedge clk) user_rst_start = 0;
    c = 0;
    tb = 0;
    while (srst_pull && c < 100) begin
      if (trst_pull) tb++;
      c++;
      @(negedge clk);
    end
    chk(c == ((p < 1) ? 1 : p), "R6 pulse width", c, (p < 1) ? 1 : p);
    chk(tb == 0 && !ready, "R6 trst idle and not ready", tb, 0);
    cyc(4);
  endtask

  task automatic t_latch(input bit halt_en);
    latch_en = 1;
    halt_on_rst = halt_en;
    @(negedge clk) tgt_pull = 1;
    @(negedge clk) tgt_pull = 0;
    @(negedge clk);
    chk(!tgt_rst_seen && !halt_req, "R7 flag not yet set", int'(tgt_rst_seen), 0);
    @(negedge clk);
    chk(tgt_rst_seen == 1, "R7 short pulse captured", int'(tgt_rst_seen), 1);
    chk(halt_req == halt_en, "R9 halt pulse", int'(halt_req), int'(halt_en));
    @(negedge clk);
    chk(halt_req == 0, "R9 halt one cycle", int'(halt_req), 0);
    cyc(10);
    chk(tgt_rst_seen == 1, "R7 flag sticky", int'(tgt_rst_seen), 1);
    status_read = 1;
    @(negedge clk) status_read = 0;
    chk(tgt_rst_seen == 0, "R7 cleared on read", int'(tgt_rst_seen), 0);
    halt_on_rst = 0;
  endtask

  task automatic t_nolatch();
    latch_en = 0;
    @(negedge clk) tgt_pull = 1;
    cyc(5);
    chk(tgt_rst_seen == 1, "R8 live level seen", int'(tgt_rst_seen), 1);
    chk(halt_req == 0, "R9 no halt when disabled", int'(halt_req), 0);
    tgt_pull = 0;
    cyc(2);
    chk(tgt_rst_seen == 1, "R8 follows with sync delay", int'(tgt_rst_seen), 1);
    @(negedge clk);
    chk(tgt_rst_seen == 0, "R8 drops without read", int'(tgt_rst_seen), 0);
    latch_en = 1;
  endtask

  task automatic t_hot();
    int drv;
    hot_attach = 1;
    @(negedge clk) connect_start = 1;
    @(negedge clk) connect_start = 0;
    drv = 0;
    for (int i = 0; i < 6; i++) begin
      if (srst_pull || trst_pull || cfg_req) drv++;
      @(negedge clk);
    end
    chk(attach_safe == 1, "R10 attach safe", int'(attach_safe), 1);
    chk(drv == 0, "R10 lines left floating", drv, 0);
    hot_attach = 0;
  endtask

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1;
    cyc(2);
    t_reset();
    t_connect(3, 5);
    t_connect(0, 0);
    t_connect(1, 1);
    t_timeout(6);
    t_timeout(0);
    t_user_pulse(4);
    t_user_pulse(0);
    t_latch(1'b1);
    t_latch(1'b0);
    t_nolatch();
    t_hot();
    go_idle();
    t_user_pulse(2);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule